// File: doc/BRIEF.md
# Spreading-Code Generator with Epoch Counter

This block is the code section of one satellite tracking channel. It produces a 1023-chip Gold sequence whose member is picked by a loaded 10-bit key. The sequence is paced by a code NCO. The code appears as three replicas, early, prompt and late, each half a chip behind the one before it. Software can delay the code phase by a programmed number of half-chips, and it can hold the generator cleared through a clear control.

The block counts whole code periods in an epoch counter. The live count is always readable, and software can overwrite it. A shared TIC strobe latches a snapshot of the epoch count, the half-chip position within the code and the NCO phase. The bring-up order is as follows: write the key, then the NCO increment, then the slew, while the clear control is held high, and then drop the clear control.

Top module: `cagen_chan`

## Requirements
- R1: The key sets the start state of the second generator register. Bit i of each 10-bit register is stage i+1. The first register starts at all ones with feedback taps 3 and 10. The second register starts at the key with feedback taps 2, 3, 6, 8, 9 and 10. Each register shifts toward bit 9, with the feedback entering bit 0. The `early` output is bit 9 of the first register XOR bit 9 of the second.
- R2: The code NCO adds the increment to a 32-bit phase on every clock. Each carry out is one half-chip tick, and two ticks advance the code by one chip. With an increment of 2^32/P, tick n arrives at clock edge n·P after the clear is released.
- R3: While `prn_clear` is high, the following are held at their start values: the NCO phase (0), both registers, the chip and half-chip counters (0), the replica delay line (0) and `dump` (0). The epoch count is not affected.
- R4: `prompt` repeats `early` one half-chip tick later, and `late` repeats it two ticks later. Both read 0 until that many ticks have been taken after a clear.
- R5: After a slew value S is written, the next S half-chip ticks are absorbed without moving the code. Normal stepping then resumes.
- R6: `dump` is high for exactly one cycle, right after the clock edge on which the code steps from chip 1022 back to chip 0. Both registers restart at that edge.
- R7: `epoch_live` increments at the same edge that starts a `dump` pulse.
- R8: A high `tic` copies the epoch count held before that edge into `epoch_tic`. The copy holds until the next `tic`, even if the live count is loaded or advances.
- R9: A high `tic` also captures the half-chip position (2·chip + half-chip bit) and the NCO phase held before that edge.
- R10: An epoch load write replaces the live count at the next edge. It takes priority over a code wrap at the same edge.
- R11: During reset, `dump`, `prompt`, `late`, the epoch values and the captured measurements all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prn_clear | input | 1 | Hold generator cleared while high |
| key_we | input | 1 | Key write strobe |
| key_wdata | input | 10 | Start state for the second register |
| incr_we | input | 1 | NCO increment write strobe |
| incr_wdata | input | 32 | NCO increment per clock |
| slew_we | input | 1 | Slew write strobe |
| slew_wdata | input | 11 | Half-chip ticks to absorb |
| epoch_we | input | 1 | Epoch load strobe |
| epoch_wdata | input | 16 | Value for the epoch counter |
| tic | input | 1 | Measurement latch strobe |
| early | output | 1 | Early code replica |
| prompt | output | 1 | Prompt code replica |
| late | output | 1 | Late code replica |
| dump | output | 1 | One-cycle code-period strobe |
| epoch_live | output | 16 | Running epoch count |
| epoch_tic | output | 16 | Epoch count captured on TIC |
| meas_halfchip | output | 11 | Half-chip position captured on TIC |
| meas_phase | output | 32 | NCO phase captured on TIC |

## Verification
Everything is counted in clock edges from the negative edge where the clear is released. The replicas are combinational from registers that move on tick edges, so after edge c they reflect floor(c/P) ticks less the slew. `dump` and the epoch step become visible right after edge (S+2046)·P. Register writes and `tic` land on the first edge after they are driven, and a capture reflects the state of the cycle before that edge. The bench drives inputs on the falling edge and samples after the following falling edge, which places every comparison one full edge after its cause.

// File: rtl/cagen_pkg.sv
// Shared constants and helpers for the spreading-code channel.
// Assumes a 10-stage generator pair and a 1023-chip code period.
package cagen_pkg;
    localparam int LFSR_W   = 10;
    localparam int CODE_LEN = 1023;
    localparam int CHIP_W   = $clog2(CODE_LEN);
    localparam int HC_W     = CHIP_W + 1;
    localparam int NCO_W    = 32;

    // Feedback tap masks: bit i stands for stage i+1.
    localparam logic [LFSR_W-1:0] G1_MASK = 10'h204;
    localparam logic [LFSR_W-1:0] G2_MASK = 10'h3A6;

    // One shift toward the top stage with XOR feedback from the masked stages.
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s,
                                                    input logic [LFSR_W-1:0] m);
        return {s[LFSR_W-2:0], ^(s & m)};
    endfunction

    typedef struct packed {
        logic [HC_W-1:0]  halfchip;
        logic [NCO_W-1:0] phase;
    } code_meas_t;
endpackage

// File: rtl/cagen_nco.sv
// Code NCO: phase accumulator whose carry out marks a half-chip tick.
// Assumes the increment is written while the channel is held cleared.
module cagen_nco
    import cagen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             incr_we,
    input  logic [NCO_W-1:0] incr_wdata,
    output logic             tick,
    output logic [NCO_W-1:0] phase
);
    logic [NCO_W-1:0] incr_q;
    logic [NCO_W-1:0] phase_q;
    logic [NCO_W:0]   sum;

    // Next phase with carry.
    always_comb sum = {1'b0, phase_q} + {1'b0, incr_q};

    assign tick  = sum[NCO_W] & ~clear;
    assign phase = phase_q;

    // Increment register.
    always_ff @(posedge clk) begin
        if (!rst_n)       incr_q <= '0;
        else if (incr_we) incr_q <= incr_wdata;
    end

    // Phase accumulator, zeroed while cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) phase_q <= '0;
        else                 phase_q <= sum[NCO_W-1:0];
    end

    // R2: a carry always leaves the phase below where it was.
    a_r2_carry_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (phase_q < $past(phase_q)));
    // R3: clear zeroes the phase.
    a_r3_phase_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (phase_q == '0));
endmodule

// File: rtl/cagen_gen.sv
// Gold code generator with slew hold and half-chip replica delay line.
// Assumes DLY_TAPS is even and at least 2; prompt sits at the middle tap.
module cagen_gen
    import cagen_pkg::*;
#(
    parameter int SLEW_W   = 11,
    parameter int DLY_TAPS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              key_we,
    input  logic [LFSR_W-1:0] key_wdata,
    input  logic              slew_we,
    input  logic [SLEW_W-1:0] slew_wdata,
    input  logic              tick,
    output logic              early,
    output logic              prompt,
    output logic              late,
    output logic              wrap_now,
    output logic              dump,
    output logic [HC_W-1:0]   halfchip
);
    localparam int PROMPT_IDX = DLY_TAPS / 2 - 1;
    localparam int LATE_IDX   = DLY_TAPS - 1;
    localparam logic [CHIP_W-1:0] LAST_CHIP = CHIP_W'(CODE_LEN - 1);
    localparam logic [LFSR_W-1:0] ALL_ONES  = '1;

    logic [LFSR_W-1:0]   key_q;
    logic [LFSR_W-1:0]   g1_q;
    logic [LFSR_W-1:0]   g2_q;
    logic [CHIP_W-1:0]   chip_q;
    logic                hp_q;
    logic [SLEW_W-1:0]   slew_q;
    logic [DLY_TAPS-1:0] dly_q;
    logic                dump_q;
    logic                step;
    logic                chip_bit;

    // A tick moves the code only when no slew is pending.
    always_comb begin
        step     = tick && (slew_q == '0);
        chip_bit = g1_q[LFSR_W-1] ^ g2_q[LFSR_W-1];
        wrap_now = step && hp_q && (chip_q == LAST_CHIP);
    end

    assign early    = chip_bit;
    assign prompt   = dly_q[PROMPT_IDX];
    assign late     = dly_q[LATE_IDX];
    assign dump     = dump_q;
    assign halfchip = {chip_q, hp_q};

    // Key register.
    always_ff @(posedge clk) begin
        if (!rst_n)      key_q <= '0;
        else if (key_we) key_q <= key_wdata;
    end

    // Slew counter: load on write, drain one per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                     slew_q <= '0;
        else if (slew_we)               slew_q <= slew_wdata;
        else if (tick && slew_q != '0)  slew_q <= slew_q - 1'b1;
    end

    // Generator registers and chip/half-chip position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g1_q <= ALL_ONES; g2_q <= '0; chip_q <= '0; hp_q <= 1'b0;
        end else if (clear) begin
            g1_q <= ALL_ONES; g2_q <= key_q; chip_q <= '0; hp_q <= 1'b0;
        end else if (step) begin
            hp_q <= ~hp_q;
            if (hp_q) begin
                if (chip_q == LAST_CHIP) begin
                    g1_q <= ALL_ONES; g2_q <= key_q; chip_q <= '0;
                end else begin
                    g1_q   <= lfsr_step(g1_q, G1_MASK);
                    g2_q   <= lfsr_step(g2_q, G2_MASK);
                    chip_q <= chip_q + 1'b1;
                end
            end
        end
    end

    // Half-chip delay line feeding prompt and late.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) dly_q <= '0;
        else if (step)       dly_q <= {dly_q[DLY_TAPS-2:0], chip_bit};
    end

    // Period strobe, one cycle after the wrap edge.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) dump_q <= 1'b0;
        else                 dump_q <= wrap_now;
    end

    // R6: the period strobe lasts a single cycle.
    a_r6_dump_single: assert property (@(posedge clk) disable iff (!rst_n)
        dump |=> !dump);
    // R5: a tick absorbed by the slew leaves the code position alone.
    a_r5_slew_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && slew_q != '0) |=> $stable(halfchip));
    // R2: no tick, no movement.
    a_r2_no_tick_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(halfchip));
    // R3: clear returns position, delay line and strobe to rest.
    a_r3_clear_rest: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (halfchip == '0 && !prompt && !late && !dump));
endmodule

// File: rtl/cagen_epoch.sv
// Epoch counter with load, plus the TIC snapshot of epoch and code position.
// Assumes tic is a single-cycle strobe synchronous to clk.
module cagen_epoch
    import cagen_pkg::*;
#(
    parameter int EPOCH_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wrap_now,
    input  logic               load_we,
    input  logic [EPOCH_W-1:0] load_data,
    input  logic               tic,
    input  code_meas_t         meas_in,
    output logic [EPOCH_W-1:0] live,
    output logic [EPOCH_W-1:0] latched,
    output code_meas_t         meas_out
);
    logic [EPOCH_W-1:0] epoch_q;
    logic [EPOCH_W-1:0] latch_q;
    code_meas_t         meas_q;

    assign live     = epoch_q;
    assign latched  = latch_q;
    assign meas_out = meas_q;

    // Running count; a load beats a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)        epoch_q <= '0;
        else if (load_we)  epoch_q <= load_data;
        else if (wrap_now) epoch_q <= epoch_q + 1'b1;
    end

    // Snapshot on TIC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            meas_q  <= '0;
        end else if (tic) begin
            latch_q <= epoch_q;
            meas_q  <= meas_in;
        end
    end

    // R8: snapshot holds between TICs.
    a_r8_snapshot_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !tic |=> $stable(latched));
    // R8: snapshot equals the count held before the TIC edge.
    a_r8_snapshot_value: assert property (@(posedge clk) disable iff (!rst_n)
        tic |=> (latched == $past(live)));
    // R10: a load lands regardless of a wrap.
    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> (live == $past(load_data)));
    // R7: a wrap without load advances by one.
    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_now && !load_we) |=> ((live - $past(live)) == EPOCH_W'(1)));
endmodule

// File: rtl/cagen_chan.sv
// Top of the per-channel code section: NCO, generator and epoch logic.
// Assumes configuration writes are made while prn_clear is held high.
module cagen_chan
    import cagen_pkg::*;
#(
    parameter int SLEW_W   = 11,
    parameter int EPOCH_W  = 16,
    parameter int DLY_TAPS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prn_clear,
    input  logic               key_we,
    input  logic [LFSR_W-1:0]  key_wdata,
    input  logic               incr_we,
    input  logic [NCO_W-1:0]   incr_wdata,
    input  logic               slew_we,
    input  logic [SLEW_W-1:0]  slew_wdata,
    input  logic               epoch_we,
    input  logic [EPOCH_W-1:0] epoch_wdata,
    input  logic               tic,
    output logic               early,
    output logic               prompt,
    output logic               late,
    output logic               dump,
    output logic [EPOCH_W-1:0] epoch_live,
    output logic [EPOCH_W-1:0] epoch_tic,
    output logic [HC_W-1:0]    meas_halfchip,
    output logic [NCO_W-1:0]   meas_phase
);
    logic             tick;
    logic [NCO_W-1:0] phase;
    logic             wrap_now;
    logic [HC_W-1:0]  halfchip;
    code_meas_t       meas_now;
    code_meas_t       meas_cap;

    cagen_nco u_nco (
        .clk(clk), .rst_n(rst_n), .clear(prn_clear),
        .incr_we(incr_we), .incr_wdata(incr_wdata),
        .tick(tick), .phase(phase)
    );

    cagen_gen #(.SLEW_W(SLEW_W), .DLY_TAPS(DLY_TAPS)) u_gen (
        .clk(clk), .rst_n(rst_n), .clear(prn_clear),
        .key_we(key_we), .key_wdata(key_wdata),
        .slew_we(slew_we), .slew_wdata(slew_wdata),
        .tick(tick), .early(early), .prompt(prompt), .late(late),
        .wrap_now(wrap_now), .dump(dump), .halfchip(halfchip)
    );

    // Live code position bundled for the snapshot.
    always_comb begin
        meas_now.halfchip = halfchip;
        meas_now.phase    = phase;
    end

    cagen_epoch #(.EPOCH_W(EPOCH_W)) u_epoch (
        .clk(clk), .rst_n(rst_n), .wrap_now(wrap_now),
        .load_we(epoch_we), .load_data(epoch_wdata), .tic(tic),
        .meas_in(meas_now), .live(epoch_live), .latched(epoch_tic),
        .meas_out(meas_cap)
    );

    assign meas_halfchip = meas_cap.halfchip;
    assign meas_phase    = meas_cap.phase;
endmodule

// File: tb/sim_cagen_chan.sv
`timescale 1ns/1ps
module sim_cagen_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prn_clear = 1'b1;
    logic        key_we = 1'b0;
    logic [9:0]  key_wdata = '0;
    logic        incr_we = 1'b0;
    logic [31:0] incr_wdata = '0;
    logic        slew_we = 1'b0;
    logic [10:0] slew_wdata = '0;
    logic        epoch_we = 1'b0;
    logic [15:0] epoch_wdata = '0;
    logic        tic = 1'b0;
    logic        early, prompt, late, dump;
    logic [15:0] epoch_live, epoch_tic;
    logic [10:0] meas_halfchip;
    logic [31:0] meas_phase;

    int checks = 0;
    int errors = 0;
    int c = 0;
    bit seq [1023];

    // Stimulus and expected first-dump edge per vector: (S+2046)*P.
    localparam logic [9:0] V_KEY  [4] = '{10'h3EC, 10'h1B5, 10'h000, 10'h3FF};
    localparam int         V_P    [4] = '{2, 4, 2, 8};
    localparam int         V_SLEW [4] = '{0, 3, 5, 0};
    localparam int         V_DUMP [4] = '{4092, 8196, 4102, 16368};

    always #2 clk = ~clk;

    cagen_chan u0 (
        .clk(clk), .rst_n(rst_n), .prn_clear(prn_clear),
        .key_we(key_we), .key_wdata(key_wdata),
        .incr_we(incr_we), .incr_wdata(incr_wdata),
        .slew_we(slew_we), .slew_wdata(slew_wdata),
        .epoch_we(epoch_we), .epoch_wdata(epoch_wdata), .tic(tic),
        .early(early), .prompt(prompt), .late(late), .dump(dump),
        .epoch_live(epoch_live), .epoch_tic(epoch_tic),
        .meas_halfchip(meas_halfchip), .meas_phase(meas_phase)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (edge %0d)", tag, act, exp, c);
        end
    endtask

    // Bench model of the code from R1.
    task automatic build_seq(input logic [9:0] key);
        logic [9:0] a = 10'h3FF;
        logic [9:0] b = key;
        for (int i = 0; i < 1023; i++) begin
            seq[i] = a[9] ^ b[9];
            a = {a[8:0], a[2] ^ a[9]};
            b = {b[8:0], b[1] ^ b[2] ^ b[5] ^ b[7] ^ b[8] ^ b[9]};
        end
    endtask

    function automatic logic [2:0] exp_epl(input int cc, input int p, input int s);
        int t = cc / p;
        int h = (t >= s) ? t - s : 0;
        logic e = seq[(h / 2) % 1023];
        logic pr = (h >= 1) ? seq[((h - 1) / 2) % 1023] : 1'b0;
        logic la = (h >= 2) ? seq[((h - 2) / 2) % 1023] : 1'b0;
        return {e, pr, la};
    endfunction

    task automatic step();
        @(posedge clk);
        c++;
        @(negedge clk);
    endtask

    // Configure under clear, then release; c counts edges after release.
    task automatic setup(input logic [9:0] key, input int p, input int s, input logic [15:0] ep);
        prn_clear = 1'b1;
        key_we = 1'b1; key_wdata = key;
        incr_we = 1'b1; incr_wdata = 32'(64'h1_0000_0000 / p);
        slew_we = 1'b1; slew_wdata = 11'(s);
        epoch_we = 1'b1; epoch_wdata = ep;
        @(negedge clk);
        key_we = 1'b0; incr_we = 1'b0; slew_we = 1'b0; epoch_we = 1'b0;
        @(negedge clk);
        @(negedge clk);
        prn_clear = 1'b0;
        c = 0;
        build_seq(key);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 dump", 64'(dump), 0);
        chk("R11 prompt/late", 64'({prompt, late}), 0);
        chk("R11 epoch_live", 64'(epoch_live), 0);
        chk("R11 epoch_tic", 64'(epoch_tic), 0);
        chk("R11 meas", 64'({meas_halfchip, meas_phase}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 R2 R4 R5 R6 R7 every edge.
        for (int v = 0; v < 4; v++) begin
            setup(V_KEY[v], V_P[v], V_SLEW[v], 16'd0);
            while (c < V_DUMP[v] + 4 * V_P[v]) begin
                step();
                chk("R1/R2/R4/R5 replicas", 64'({early, prompt, late}),
                    64'(exp_epl(c, V_P[v], V_SLEW[v])));
                chk("R6 dump", 64'(dump), 64'(c == V_DUMP[v]));
                chk("R7 epoch_live", 64'(epoch_live), 64'(c >= V_DUMP[v]));
            end
        end

        // Directed: TIC capture, epoch load, load vs wrap, clear mid-run.
        setup(10'h3EC, 2, 0, 16'd5);
        while (c < 4999) step();
        tic = 1'b1; step(); tic = 1'b0;
        chk("R8 epoch_tic", 64'(epoch_tic), 6);
        chk("R9 halfchip", 64'(meas_halfchip), 453);
        chk("R9 phase", 64'(meas_phase), 64'h8000_0000);
        chk("R7 live after wrap", 64'(epoch_live), 6);
        epoch_we = 1'b1; epoch_wdata = 16'd9; step(); epoch_we = 1'b0;
        chk("R10 load", 64'(epoch_live), 9);
        chk("R8 snapshot unchanged by load", 64'(epoch_tic), 6);
        tic = 1'b1; step(); tic = 1'b0;
        chk("R8 second snapshot", 64'(epoch_tic), 9);
        chk("R9 second halfchip", 64'(meas_halfchip), 454);
        chk("R9 second phase", 64'(meas_phase), 64'h8000_0000);
        while (c < 8183) step();
        epoch_we = 1'b1; epoch_wdata = 16'd20; step(); epoch_we = 1'b0;
        chk("R10 load beats wrap", 64'(epoch_live), 20);
        chk("R6 dump at second wrap", 64'(dump), 1);
        prn_clear = 1'b1; step();
        chk("R3 early at start", 64'(early), 64'(seq[0]));
        chk("R3 prompt/late cleared", 64'({prompt, late}), 0);
        chk("R3 dump cleared", 64'(dump), 0);
        chk("R3 epoch kept", 64'(epoch_live), 20);
        tic = 1'b1; step(); tic = 1'b0;
        chk("R3 halfchip cleared", 64'(meas_halfchip), 0);
        chk("R3 phase cleared", 64'(meas_phase), 0);
        chk("R8 snapshot under clear", 64'(epoch_tic), 20);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule